// File: doc/BRIEF.md
# MII Link and Duplex Resolver

This block is a small sequencer that sits in front of the request port of an MDIO master. When it gets a start pulse, it reads two registers of one PHY: the basic status register and the link-partner ability register. From the two values and a local advertisement word, it decides three things: whether a PHY answers at all, whether the link is up, and which speed class and duplex were negotiated. It then keeps a two-bit MAC mode word up to date. That word holds a full-duplex bit and a transmit-threshold bit.

The link bit in the status register is latched low. For that reason, a status read with the link bit clear is followed by exactly one confirming re-read before the block reports that there is no link. Each run ends with a one-cycle result strobe that carries a two-bit code. When the mode word really changes, a one-cycle MAC restart request is raised in the same cycle. The MDIO wire protocol and the MAC datapath are outside this block.

Top module: `mii_link_resolver`

## Requirements
- R1: A start pulse accepted while idle issues a read of register 1 at `phy_addr`, then a read of register 5 at the same address. Each read is a one-cycle `mdio_cmd_valid` pulse, and the next read waits for the `mdio_rd_done` of the previous one.
- R2: A first status value of 0xFFFF ends the run with code 3 (PHY absent). No re-read is issued, the mode word is left unchanged and no restart is raised.
- R3: If bit 2 of the first status value is clear, one more register-1 read is issued. If bit 2 of the second value is also clear, the run ends with code 2 (no link) and the mode word is unchanged.
- R4: If the re-read shows bit 2 set, the run goes on to the mode decision as if the link had been up from the start.
- R5: The negotiated set is partner ability AND local advertisement. `mode_txthr` becomes 0 when any of bits 9:7 of the negotiated set is 1, and becomes 1 otherwise.
- R6: Without `duplex_lock`, `mode_fdx` becomes 1 when negotiated bit 8 is set, or when bits 8:6 equal 3'b001; otherwise it becomes 0. With `duplex_lock` high, `mode_fdx` keeps its stored value.
- R7: If the new mode word differs from the stored one, it is stored, `mac_restart` pulses together with the result strobe, and the code is 1 (changed). Otherwise the code is 0 (unchanged), with no restart and no change to the mode word.
- R8: `result_valid` is high for one cycle, and `busy` is low in that cycle. A start pulse that arrives while `busy` is high is ignored and issues no extra read.
- R9: After reset, `busy`, `result_valid`, `mac_restart`, `mdio_cmd_valid`, `mode_fdx` and `mode_txthr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one resolve run (ignored while busy) |
| phy_addr | input | 5 | Address of the primary PHY |
| local_adv | input | 16 | Local advertisement word |
| duplex_lock | input | 1 | Keep the stored duplex bit |
| mdio_cmd_valid | output | 1 | One-cycle read request to the MDIO master |
| mdio_cmd_phy | output | 5 | PHY address of the request |
| mdio_cmd_reg | output | 5 | Register number of the request |
| mdio_rd_done | input | 1 | Read completion strobe from the MDIO master |
| mdio_rd_data | input | 16 | Read data, valid with `mdio_rd_done` |
| busy | output | 1 | A run is in progress |
| result_valid | output | 1 | One-cycle end-of-run strobe |
| result_code | output | 2 | 0 unchanged, 1 changed, 2 no link, 3 absent |
| mac_restart | output | 1 | One-cycle MAC restart request |
| mode_fdx | output | 1 | Mode word full-duplex bit |
| mode_txthr | output | 1 | Mode word transmit-threshold bit |

## Verification
The bench targets the following cases:
- A failed first link read that recovers on the re-read. A design without the confirming read would report no link here.
- An all-ones status. A design that checks the link bit first would misread it as an up link and rewrite the mode word.
- A negotiated set with bits 8:6 equal to 3'b011. Testing bit 6 alone would wrongly resolve full duplex.
- The duplex lock, and a repeated identical run. A design that compared the wrong words would either overwrite the locked duplex or raise a spurious restart.
- A start pulse injected mid-run. A design that accepted it would issue a fourth read or a second result strobe.

// File: rtl/mii_res_pkg.sv
package mii_res_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_W_STAT,
    SQ_W_PART,
    SQ_CHECK,
    SQ_W_RECHK
  } sq_state_t;

  typedef enum logic [1:0] {
    RES_SAME    = 2'd0,
    RES_CHANGED = 2'd1,
    RES_NOLINK  = 2'd2,
    RES_ABSENT  = 2'd3
  } res_code_t;

  typedef enum logic [1:0] {
    TERM_NONE,
    TERM_ABSENT,
    TERM_NOLINK,
    TERM_DECIDE
  } term_t;

endpackage

// File: rtl/mii_rd_seq.sv
module mii_rd_seq
  import mii_res_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int REG_W    = 5,
  parameter int STAT_REG = 1,
  parameter int PART_REG = 5,
  parameter int LINK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_phy,
  output logic [REG_W-1:0]  cmd_reg,
  output logic              busy,
  output term_t             term,
  output logic [DATA_W-1:0] part_q
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [REG_W-1:0]  STAT_ADR = REG_W'(STAT_REG);
  localparam logic [REG_W-1:0]  PART_ADR = REG_W'(PART_REG);

  sq_state_t         state;
  logic [DATA_W-1:0] stat_q;

  assign busy = (state != SQ_IDLE);

  // Decide how the run ends in the evaluation and re-read states.
  always_comb begin
    term = TERM_NONE;
    case (state)
      SQ_CHECK: begin
        if (stat_q == ALL_ONES)
          term = TERM_ABSENT;
        else if (stat_q[LINK_BIT])
          term = TERM_DECIDE;
      end
      SQ_W_RECHK: begin
        if (rd_done)
          term = rd_data[LINK_BIT] ? TERM_DECIDE : TERM_NOLINK;
      end
      default: term = TERM_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cmd_valid <= 1'b0;
      cmd_phy   <= '0;
      cmd_reg   <= '0;
      stat_q    <= '0;
      part_q    <= '0;
    end else begin
      cmd_valid <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            cmd_phy   <= phy_addr;
            cmd_reg   <= STAT_ADR;
            cmd_valid <= 1'b1;
            state     <= SQ_W_STAT;
          end
        end
        SQ_W_STAT: begin
          if (rd_done) begin
            stat_q    <= rd_data;
            cmd_reg   <= PART_ADR;
            cmd_valid <= 1'b1;
            state     <= SQ_W_PART;
          end
        end
        SQ_W_PART: begin
          if (rd_done) begin
            part_q <= rd_data;
            state  <= SQ_CHECK;
          end
        end
        SQ_CHECK: begin
          if (term != TERM_NONE) begin
            state <= SQ_IDLE;
          end else begin
            cmd_reg   <= STAT_ADR;
            cmd_valid <= 1'b1;
            state     <= SQ_W_RECHK;
          end
        end
        SQ_W_RECHK: begin
          if (rd_done)
            state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mii_mode_calc.sv
module mii_mode_calc #(
  parameter int DATA_W    = 16,
  parameter int HS_LO     = 7,
  parameter int HS_HI     = 9,
  parameter int FD_HS_BIT = 8,
  parameter int FD_LS_BIT = 6
) (
  input  logic [DATA_W-1:0] part,
  input  logic [DATA_W-1:0] adv,
  input  logic              lock,
  input  logic              cur_fdx,
  output logic              nxt_fdx,
  output logic              nxt_thr
);

  localparam int FW = FD_HS_BIT - FD_LS_BIT + 1;

  logic [DATA_W-1:0] neg;
  logic [FW-1:0]     fd_field;
  logic              hs_any;
  logic              fd_resolved;

  assign neg         = part & adv;
  assign hs_any      = |neg[HS_HI:HS_LO];
  assign fd_field    = neg[FD_HS_BIT:FD_LS_BIT];
  // The fast full-duplex bit wins; slow full duplex counts only when alone.
  assign fd_resolved = neg[FD_HS_BIT] | (fd_field == FW'(1));
  assign nxt_fdx     = lock ? cur_fdx : fd_resolved;
  assign nxt_thr     = ~hs_any;

endmodule

// File: rtl/mii_link_resolver.sv
module mii_link_resolver
  import mii_res_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int REG_W    = 5,
  parameter int STAT_REG = 1,
  parameter int PART_REG = 5,
  parameter int LINK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [DATA_W-1:0] local_adv,
  input  logic              duplex_lock,
  output logic              mdio_cmd_valid,
  output logic [ADDR_W-1:0] mdio_cmd_phy,
  output logic [REG_W-1:0]  mdio_cmd_reg,
  input  logic              mdio_rd_done,
  input  logic [DATA_W-1:0] mdio_rd_data,
  output logic              busy,
  output logic              result_valid,
  output logic [1:0]        result_code,
  output logic              mac_restart,
  output logic              mode_fdx,
  output logic              mode_txthr
);

  term_t             term;
  logic [DATA_W-1:0] part_q;
  logic              nxt_fdx;
  logic              nxt_thr;
  logic              differs;

  mii_rd_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W),
    .STAT_REG(STAT_REG), .PART_REG(PART_REG), .LINK_BIT(LINK_BIT)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .phy_addr (phy_addr),
    .rd_done  (mdio_rd_done),
    .rd_data  (mdio_rd_data),
    .cmd_valid(mdio_cmd_valid),
    .cmd_phy  (mdio_cmd_phy),
    .cmd_reg  (mdio_cmd_reg),
    .busy     (busy),
    .term     (term),
    .part_q   (part_q)
  );

  mii_mode_calc #(.DATA_W(DATA_W)) u_calc (
    .part   (part_q),
    .adv    (local_adv),
    .lock   (duplex_lock),
    .cur_fdx(mode_fdx),
    .nxt_fdx(nxt_fdx),
    .nxt_thr(nxt_thr)
  );

  assign differs = (nxt_fdx != mode_fdx) || (nxt_thr != mode_txthr);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_fdx     <= 1'b0;
      mode_txthr   <= 1'b0;
      result_valid <= 1'b0;
      result_code  <= RES_SAME;
      mac_restart  <= 1'b0;
    end else begin
      result_valid <= (term != TERM_NONE);
      mac_restart  <= 1'b0;
      case (term)
        TERM_ABSENT: result_code <= RES_ABSENT;
        TERM_NOLINK: result_code <= RES_NOLINK;
        TERM_DECIDE: begin
          if (differs) begin
            mode_fdx    <= nxt_fdx;
            mode_txthr  <= nxt_thr;
            mac_restart <= 1'b1;
            result_code <= RES_CHANGED;
          end else begin
            result_code <= RES_SAME;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mii_link_resolver_chk.sv
module mii_link_resolver_chk #(
  parameter int REG_W    = 5,
  parameter int STAT_REG = 1,
  parameter int PART_REG = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             mdio_cmd_valid,
  input logic [REG_W-1:0] mdio_cmd_reg,
  input logic             busy,
  input logic             result_valid,
  input logic [1:0]       result_code,
  input logic             mac_restart,
  input logic             mode_fdx,
  input logic             mode_txthr
);

  assert_reg_sel_R1: assert property (@(posedge clk) disable iff (rst)
    mdio_cmd_valid |-> (mdio_cmd_reg == REG_W'(STAT_REG) || mdio_cmd_reg == REG_W'(PART_REG)));

  assert_absent_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (result_valid && result_code == 2'd3) |-> $stable({mode_fdx, mode_txthr}));

  assert_nolink_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (result_valid && result_code == 2'd2) |-> $stable({mode_fdx, mode_txthr}));

  assert_restart_code_R7: assert property (@(posedge clk) disable iff (rst)
    mac_restart |-> (result_valid && result_code == 2'd1));

  assert_mode_move_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable({mode_fdx, mode_txthr}) |-> mac_restart);

  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  assert_result_idle_R8: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy);

endmodule

bind mii_link_resolver mii_link_resolver_chk #(
  .REG_W(REG_W), .STAT_REG(STAT_REG), .PART_REG(PART_REG)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mdio_cmd_valid(mdio_cmd_valid),
  .mdio_cmd_reg  (mdio_cmd_reg),
  .busy          (busy),
  .result_valid  (result_valid),
  .result_code   (result_code),
  .mac_restart   (mac_restart),
  .mode_fdx      (mode_fdx),
  .mode_txthr    (mode_txthr)
);

// File: tb/sim_mii_link_resolver.sv
module sim_mii_link_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  phy_addr = 5'd1;
  logic [15:0] local_adv = 16'h0;
  logic        duplex_lock = 1'b0;
  logic        mdio_cmd_valid;
  logic [4:0]  mdio_cmd_phy;
  logic [4:0]  mdio_cmd_reg;
  logic        mdio_rd_done = 1'b0;
  logic [15:0] mdio_rd_data = 16'h0;
  logic        busy;
  logic        result_valid;
  logic [1:0]  result_code;
  logic        mac_restart;
  logic        mode_fdx;
  logic        mode_txthr;

  mii_link_resolver u0 (
    .clk(clk), .rst(rst), .start(start), .phy_addr(phy_addr),
    .local_adv(local_adv), .duplex_lock(duplex_lock),
    .mdio_cmd_valid(mdio_cmd_valid), .mdio_cmd_phy(mdio_cmd_phy),
    .mdio_cmd_reg(mdio_cmd_reg), .mdio_rd_done(mdio_rd_done),
    .mdio_rd_data(mdio_rd_data), .busy(busy), .result_valid(result_valid),
    .result_code(result_code), .mac_restart(mac_restart),
    .mode_fdx(mode_fdx), .mode_txthr(mode_txthr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  int          phy_bad = 0;
  logic [15:0] stat_src[$];
  logic [15:0] part_word = 16'h0;
  int          reg_log[$];
  bit          m_fdx = 1'b0;
  bit          m_thr = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural MDIO master: answers each request LAT cycles later.
  initial begin
    int          pend = 0;
    logic [15:0] pdata = 16'h0;
    forever begin
      @(negedge clk);
      mdio_rd_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mdio_rd_done = 1'b1;
          mdio_rd_data = pdata;
        end
      end
      if (mdio_cmd_valid) begin
        reg_log.push_back(int'(mdio_cmd_reg));
        if (mdio_cmd_phy != phy_addr) phy_bad++;
        if (mdio_cmd_reg == 5'd1)
          pdata = (stat_src.size() > 0) ? stat_src.pop_front() : 16'hFFFF;
        else
          pdata = part_word;
        pend = LAT;
      end
    end
  end

  task automatic run_case(input string tag, input logic [15:0] s1,
                          input logic [15:0] s2, input logic [15:0] part,
                          input logic [15:0] adv, input bit lock,
                          input logic [4:0] phy, input bit poke);
    logic [15:0] neg;
    int  exp_code;
    int  exp_reads;
    bit  n_fdx;
    bit  n_thr;
    bit  seen = 1'b0;
    int  clk_err = 0;
    int  extra = 0;
    neg   = part & adv;
    n_thr = ((neg & 16'h0380) == 16'h0);
    n_fdx = lock ? m_fdx : (((neg & 16'h0100) != 0) || ((neg & 16'h01C0) == 16'h0040));
    if (s1 == 16'hFFFF) begin
      exp_code = 3; exp_reads = 2; n_fdx = m_fdx; n_thr = m_thr;
    end else if (!s1[2] && !s2[2]) begin
      exp_code = 2; exp_reads = 3; n_fdx = m_fdx; n_thr = m_thr;
    end else begin
      exp_reads = s1[2] ? 2 : 3;
      exp_code  = (n_fdx != m_fdx || n_thr != m_thr) ? 1 : 0;
    end
    stat_src.delete();
    stat_src.push_back(s1);
    stat_src.push_back(s2);
    reg_log.delete();
    part_word = part; local_adv = adv; duplex_lock = lock; phy_addr = phy;
    phy_bad = 0;
    @(negedge clk);
    start = 1'b1;
    for (int n = 0; n < 300 && !seen; n++) begin
      @(negedge clk);
      start = (poke && n == 3);
      if (result_valid) begin
        seen = 1'b1;
        chk(int'(result_code) == exp_code, tag, "result code", result_code, exp_code);
        chk(mac_restart == (exp_code == 1), tag, "R7 restart", mac_restart, exp_code == 1);
        chk({mode_fdx, mode_txthr} == {n_fdx, n_thr}, tag, "mode word",
            {mode_fdx, mode_txthr}, {n_fdx, n_thr});
        chk(!busy, "R8", "busy at result", busy, 0);
      end else begin
        if (mac_restart || {mode_fdx, mode_txthr} != {m_fdx, m_thr}) clk_err++;
      end
    end
    start = 1'b0;
    chk(seen, "R8", {tag, " result seen"}, seen, 1);
    chk(clk_err == 0, "R7", {tag, " mode held before result"}, clk_err, 0);
    m_fdx = n_fdx; m_thr = n_thr;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (result_valid || mac_restart || busy) extra++;
      if ({mode_fdx, mode_txthr} != {m_fdx, m_thr}) clk_err++;
    end
    chk(extra == 0, "R8", {tag, " single result"}, extra, 0);
    chk(clk_err == 0, "R7", {tag, " mode held after"}, clk_err, 0);
    chk(reg_log.size() == exp_reads, "R1", {tag, " read count"}, reg_log.size(), exp_reads);
    if (reg_log.size() >= 2)
      chk(reg_log[0] == 1 && reg_log[1] == 5, "R1", {tag, " read order"},
          reg_log[0] * 16 + reg_log[1], 8'h15);
    chk(phy_bad == 0, "R1", {tag, " phy address"}, phy_bad, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(!busy && !result_valid && !mac_restart && !mdio_cmd_valid, "R9", "idle outputs",
        {busy, result_valid, mac_restart, mdio_cmd_valid}, 0);
    chk(!mode_fdx && !mode_txthr, "R9", "mode after reset", {mode_fdx, mode_txthr}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_case("R2 absent",        16'hFFFF, 16'h782D, 16'h01E1, 16'h01E1, 0, 5'd1, 0);
    run_case("R3 no link",       16'h7809, 16'h7809, 16'h01E1, 16'h01E1, 0, 5'd2, 0);
    run_case("R6 fast full",     16'h782D, 16'h782D, 16'h45E1, 16'h01E1, 0, 5'd1, 0);
    run_case("R7 repeat same",   16'h782D, 16'h782D, 16'h45E1, 16'h01E1, 0, 5'd1, 0);
    run_case("R4 reread up",     16'h7809, 16'h782D, 16'h0061, 16'h01E1, 0, 5'd3, 0);
    run_case("R5 slow half",     16'h782D, 16'h782D, 16'h0021, 16'h01E1, 0, 5'd1, 0);
    run_case("R6 bits 011",      16'h782D, 16'h782D, 16'h00C1, 16'h01E1, 0, 5'd1, 0);
    run_case("R5 adv mask",      16'h782D, 16'h782D, 16'h01E1, 16'h0061, 0, 5'd4, 0);
    run_case("R6 lock keep",     16'h782D, 16'h782D, 16'h0021, 16'h01E1, 1, 5'd1, 0);
    run_case("R6 lock thr",      16'h782D, 16'h782D, 16'h0181, 16'h01E1, 1, 5'd1, 0);
    run_case("R8 busy start",    16'h782D, 16'h782D, 16'h0021, 16'h01E1, 0, 5'h1B, 1);
    run_case("R2 absent later",  16'hFFFF, 16'h0000, 16'h01E1, 16'h01E1, 0, 5'd1, 0);
    run_case("R3 no link later", 16'h0000, 16'h0000, 16'h01E1, 16'h01E1, 0, 5'd1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule